// File: doc/BRIEF.md
# Palette Memory Bus Front End

This block is the processor-facing side of a palette controller. Each access uses an 8-bit data bus and a byte address. The block decodes the access to one of three 8-bit colour memories (red, green, blue) or to a small file of 16-bit control registers. A colour access reaches one pen of one channel, so three writes to the same pen set one full colour. A register access reaches one byte of one register. Register bytes are always big-endian.

The address has three parts. A two-bit bank field sits just above the low pen bits. A page field sits above the bank field. The pen index joins the page field with the low pen bits and leaves out the bank field. The register window therefore appears once in every page, and it repeats every 16 bytes inside each page. All registers are also driven as parallel outputs for the video-side logic.

Read data comes back one clock after the address, because the colour memories are synchronous RAMs. The same full-size map (four 8 KB pages, 8192 pens per channel, a 15-bit address) comes from `LOW_W = 11`. The default `LOW_W = 8` keeps the same decode rules at a smaller depth.

Top module: `palette_bus_ctrl`

## Requirements
- R1: Address bits [LOW_W+1:LOW_W] select the bank: 0 is red, 1 is green, 2 is blue, and 3 is the register window.
- R2: The pen index is {addr[ADDR_W-1:LOW_W+2], addr[LOW_W-1:0]}, which gives 4·2^LOW_W pens per channel. Every pen, including those in the top page, can be stored and read back on its own.
- R3: A colour write changes only the addressed byte of the addressed channel. The other two channels at the same pen, and all other pens, keep their values.
- R4: A read cycle (cs=1, we=0) returns the stored byte for the decoded pen and bank on rdata. The value appears after the next rising clock edge.
- R5: There are eight 16-bit registers, selected by addr[3:1]. Any address in the register window of any page reaches the same register, whatever the values of addr[LOW_W-1:4] and of the page bits.
- R6: Register bytes are big-endian. An even address (addr[0]=0) reaches bits 15:8, and an odd address reaches bits 7:0.
- R7: A register byte write leaves the other byte of that register, and every other register, unchanged.
- R8: Reset (rst high, synchronous) clears all registers to zero and drives rdata to zero.
- R9: Register k appears on regs_o[16k+15:16k]. A register write becomes visible there after the clock edge that takes the write.
- R10: rdata holds its value in every cycle that is not a read cycle, including write cycles and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Access strobe for this cycle |
| we | input | 1 | 1 = write, 0 = read (when cs=1) |
| addr | input | ADDR_W | Byte address (PAGE_W+2+LOW_W bits) |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid one clock after a read cycle |
| regs_o | output | NUM_REGS*16 | All registers side by side, register 0 in the low bits |

## Verification
The bench builds the block with its defaults: LOW_W=8 and PAGE_W=2, which gives a 12-bit address and 1024 pens per channel. At that size every pen of every channel can be filled and compared within the run. The run therefore reaches both ends of the pen range and the page-bit boundary inside the pen index. It also writes and reads the registers through mirrors in all four pages and at several 16-byte repeats. The decode works on bit positions relative to LOW_W, so the bank, page and mirror rules checked here are the ones the 15-bit map uses with LOW_W=11.

// File: rtl/pal_bus_pkg.sv
package pal_bus_pkg;

    // Bank field encoding. The register window must be code 3.
    typedef enum logic [1:0] {
        BANK_RED = 2'd0,
        BANK_GRN = 2'd1,
        BANK_BLU = 2'd2,
        BANK_REG = 2'd3
    } bank_e;

    localparam int NUM_CH = 3;

endpackage

// File: rtl/pal_addr_dec.sv
module pal_addr_dec
    import pal_bus_pkg::*;
#(
    parameter int LOW_W     = 8,
    parameter int PAGE_W    = 2,
    parameter int REG_SEL_W = 3,
    localparam int ADDR_W   = PAGE_W + 2 + LOW_W,
    localparam int PEN_W    = PAGE_W + LOW_W
) (
    input  logic [ADDR_W-1:0]    addr,
    output bank_e                bank,
    output logic [PEN_W-1:0]     pen,
    output logic [REG_SEL_W-1:0] reg_idx,
    output logic                 lo_byte
);

    always_comb begin
        bank    = bank_e'(addr[LOW_W+1:LOW_W]);
        // The bank field is left out of the pen index.
        pen     = {addr[ADDR_W-1:LOW_W+2], addr[LOW_W-1:0]};
        reg_idx = addr[REG_SEL_W:1];
        lo_byte = addr[0];
    end

endmodule

// File: rtl/pal_chan_ram.sv
module pal_chan_ram #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] dout_d, dout_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wdata;
    end

    always_comb begin
        dout_d = dout_q;
        if (rd_en) dout_d = mem[idx];
    end

    always_ff @(posedge clk) begin
        dout_q <= dout_d;
    end

    assign rdata = dout_q;

endmodule

// File: rtl/pal_reg_file.sv
module pal_reg_file #(
    parameter int NUM_REGS   = 8,
    parameter int DATA_W     = 8,
    localparam int REG_W     = 2 * DATA_W,
    localparam int REG_SEL_W = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [REG_SEL_W-1:0]       idx,
    input  logic                       lo_byte,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rd_byte,
    output logic [NUM_REGS*REG_W-1:0]  regs_flat
);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] regs;
    } rf_state_t;

    rf_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (lo_byte) state_d.regs[idx][DATA_W-1:0]     = wdata;
            else         state_d.regs[idx][REG_W-1:DATA_W] = wdata;
        end
        rd_byte = lo_byte ? state_q.regs[idx][DATA_W-1:0]
                          : state_q.regs[idx][REG_W-1:DATA_W];
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign regs_flat = state_q.regs;

endmodule

// File: rtl/palette_bus_ctrl.sv
module palette_bus_ctrl
    import pal_bus_pkg::*;
#(
    parameter int LOW_W     = 8,
    parameter int PAGE_W    = 2,
    parameter int NUM_REGS  = 8,
    localparam int DATA_W    = 8,
    localparam int REG_W     = 2 * DATA_W,
    localparam int ADDR_W    = PAGE_W + 2 + LOW_W,
    localparam int PEN_W     = PAGE_W + LOW_W,
    localparam int REG_SEL_W = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    bank_e                bank;
    logic [PEN_W-1:0]     pen;
    logic [REG_SEL_W-1:0] reg_idx;
    logic                 lo_byte;
    logic                 rd_cyc, wr_cyc;
    logic [DATA_W-1:0]    reg_rd_byte;
    logic [DATA_W-1:0]    ram_dout [NUM_CH];

    pal_addr_dec #(
        .LOW_W     (LOW_W),
        .PAGE_W    (PAGE_W),
        .REG_SEL_W (REG_SEL_W)
    ) u_dec (
        .addr    (addr),
        .bank    (bank),
        .pen     (pen),
        .reg_idx (reg_idx),
        .lo_byte (lo_byte)
    );

    assign rd_cyc = cs && !we;
    assign wr_cyc = cs && we;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pal_chan_ram #(
            .IDX_W  (PEN_W),
            .DATA_W (DATA_W)
        ) u_ram (
            .clk   (clk),
            .wr_en (wr_cyc && (bank == bank_e'(ch))),
            .rd_en (rd_cyc && (bank == bank_e'(ch))),
            .idx   (pen),
            .wdata (wdata),
            .rdata (ram_dout[ch])
        );
    end

    pal_reg_file #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_cyc && (bank == BANK_REG)),
        .idx       (reg_idx),
        .lo_byte   (lo_byte),
        .wdata     (wdata),
        .rd_byte   (reg_rd_byte),
        .regs_flat (regs_o)
    );

    // Read return path: remember which source answered, and hold the register byte.
    typedef struct packed {
        bank_e             sel;
        logic [DATA_W-1:0] reg_byte;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_cyc) begin
            rd_d.sel = bank;
            if (bank == BANK_REG) rd_d.reg_byte = reg_rd_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q.sel      <= BANK_REG;
            rd_q.reg_byte <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_comb begin
        case (rd_q.sel)
            BANK_RED: rdata = ram_dout[0];
            BANK_GRN: rdata = ram_dout[1];
            BANK_BLU: rdata = ram_dout[2];
            default:  rdata = rd_q.reg_byte;
        endcase
    end

endmodule

// File: rtl/pal_bus_chk.sv
module pal_bus_chk #(
    parameter int LOW_W    = 8,
    parameter int PAGE_W   = 2,
    parameter int NUM_REGS = 8,
    localparam int DATA_W    = 8,
    localparam int REG_W     = 2 * DATA_W,
    localparam int ADDR_W    = PAGE_W + 2 + LOW_W,
    localparam int REG_SEL_W = $clog2(NUM_REGS)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cs,
    input logic                      we,
    input logic [ADDR_W-1:0]         addr,
    input logic [DATA_W-1:0]         wdata,
    input logic [DATA_W-1:0]         rdata,
    input logic [NUM_REGS*REG_W-1:0] regs_o
);

    logic              is_reg;
    int                sel_base, oth_base;
    logic [DATA_W-1:0] sel_byte, oth_byte;
    int                sel_base_q, oth_base_q;
    logic [DATA_W-1:0] sel_byte_q, oth_byte_q, wdata_q;
    logic [DATA_W-1:0] now_sel, now_oth;

    always_comb begin
        is_reg   = (addr[LOW_W+1:LOW_W] == 2'b11);
        sel_base = int'(addr[REG_SEL_W:1]) * REG_W + (addr[0] ? 0 : DATA_W);
        oth_base = int'(addr[REG_SEL_W:1]) * REG_W + (addr[0] ? DATA_W : 0);
        sel_byte = regs_o[sel_base +: DATA_W];
        oth_byte = regs_o[oth_base +: DATA_W];
    end

    always_ff @(posedge clk) begin
        sel_base_q <= sel_base;
        oth_base_q <= oth_base;
        sel_byte_q <= sel_byte;
        oth_byte_q <= oth_byte;
        wdata_q    <= wdata;
    end

    always_comb begin
        now_sel = regs_o[sel_base_q +: DATA_W];
        now_oth = regs_o[oth_base_q +: DATA_W];
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (regs_o == '0 && rdata == '0));

    // R6
    reg_byte_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && we && is_reg) |=> (now_sel == wdata_q));

    // R7
    other_byte_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && we && is_reg) |=> (now_oth == oth_byte_q));

    // R9
    regs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(cs && we && is_reg) |=> $stable(regs_o));

    // R4
    reg_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && !we && is_reg) |=> (rdata == sel_byte_q));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cs && !we) |=> $stable(rdata));

endmodule

bind palette_bus_ctrl pal_bus_chk #(
    .LOW_W    (LOW_W),
    .PAGE_W   (PAGE_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs     (cs),
    .we     (we),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .regs_o (regs_o)
);

// File: tb/palette_bus_ctrl_tb.sv
`timescale 1ns/1ps
module palette_bus_ctrl_tb;

    localparam int LOW_W    = 8;
    localparam int PAGE_W   = 2;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = PAGE_W + 2 + LOW_W;
    localparam int PENS     = 1 << (PAGE_W + LOW_W);
    localparam int MIRRORS  = 1 << (LOW_W - 4);

    logic                       clk = 0;
    logic                       rst = 1;
    logic                       cs = 0;
    logic                       we = 0;
    logic [ADDR_W-1:0]          addr = '0;
    logic [7:0]                 wdata = '0;
    logic [7:0]                 rdata;
    logic [NUM_REGS*16-1:0]     regs_o;

    palette_bus_ctrl #(.LOW_W(LOW_W), .PAGE_W(PAGE_W), .NUM_REGS(NUM_REGS)) u_dut (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .regs_o(regs_o)
    );

    always #2.5 clk = ~clk;

    logic [7:0]  m_ch [3][PENS];
    logic [15:0] m_reg [NUM_REGS];
    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] col_addr(int b, int pen);
        int a;
        a = ((pen >> LOW_W) << (LOW_W + 2)) | (b << LOW_W) | (pen & ((1 << LOW_W) - 1));
        return ADDR_W'(a);
    endfunction

    function automatic logic [ADDR_W-1:0] reg_addr(int page, int mir, int idx, int lo);
        int a;
        a = (page << (LOW_W + 2)) | (3 << LOW_W) | (mir << 4) | (idx << 1) | lo;
        return ADDR_W'(a);
    endfunction

    function automatic int bank_of(logic [ADDR_W-1:0] a);
        return int'(a[LOW_W+1:LOW_W]);
    endfunction

    function automatic int pen_of(logic [ADDR_W-1:0] a);
        return int'({a[ADDR_W-1:LOW_W+2], a[LOW_W-1:0]});
    endfunction

    function automatic logic [7:0] exp_read(logic [ADDR_W-1:0] a);
        int b;
        b = bank_of(a);
        if (b == 3) return a[0] ? m_reg[a[3:1]][7:0] : m_reg[a[3:1]][15:8];
        return m_ch[b][pen_of(a)];
    endfunction

    task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        int b;
        @(negedge clk);
        cs = 1; we = 1; addr = a; wdata = d;
        @(posedge clk);
        #1 cs = 0; we = 0;
        b = bank_of(a);
        if (b == 3) begin
            if (a[0]) m_reg[a[3:1]][7:0]  = d;
            else      m_reg[a[3:1]][15:8] = d;
        end else begin
            m_ch[b][pen_of(a)] = d;
        end
    endtask

    task automatic rd(string req, logic [ADDR_W-1:0] a);
        @(negedge clk);
        cs = 1; we = 0; addr = a;
        @(posedge clk);
        #1 cs = 0;
        @(negedge clk);
        check(req, {24'd0, rdata}, {24'd0, exp_read(a)});
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < NUM_REGS; i++)
            check(req, {16'd0, regs_o[i*16 +: 16]}, {16'd0, m_reg[i]});
    endtask

    initial begin
        logic [7:0] hold_v;
        logic [ADDR_W-1:0] ra;
        void'($urandom(32'h5A17));
        for (int i = 0; i < NUM_REGS; i++) m_reg[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R8: reset state
        check("R8 rdata", {24'd0, rdata}, 32'd0);
        check_regs("R8 regs");

        // Fill every pen of every channel (R2 full range)
        for (int p = 0; p < PENS; p++)
            for (int b = 0; b < 3; b++)
                wr(col_addr(b, p), 8'($urandom));

        // R1: same pen, three banks, distinct values
        wr(col_addr(0, 5), 8'h11);
        wr(col_addr(1, 5), 8'h22);
        wr(col_addr(2, 5), 8'h33);
        rd("R1 red", col_addr(0, 5));
        rd("R1 green", col_addr(1, 5));
        rd("R1 blue", col_addr(2, 5));

        // R2: pen boundaries incl. top page and page-bit carry
        rd("R2 pen0", col_addr(0, 0));
        rd("R2 last pen", col_addr(2, PENS - 1));
        rd("R2 page edge lo", col_addr(1, (1 << LOW_W) - 1));
        rd("R2 page edge hi", col_addr(1, 1 << LOW_W));
        for (int p = 0; p < PENS; p += 37) rd("R2 sweep", col_addr(p % 3, p));

        // R3: blue write leaves red/green of same pen and neighbours alone
        wr(col_addr(2, 100), 8'hC3);
        rd("R3 red same pen", col_addr(0, 100));
        rd("R3 green same pen", col_addr(1, 100));
        rd("R3 blue neighbour", col_addr(2, 101));
        rd("R3 blue written", col_addr(2, 100));

        // R5/R6: write through one mirror, read through others
        wr(reg_addr(2, 3, 4, 0), 8'hAB);
        wr(reg_addr(1, 0, 4, 1), 8'hCD);
        check("R6 reg4 value", {16'd0, regs_o[4*16 +: 16]}, 32'h0000ABCD);
        rd("R5 mirror page0", reg_addr(0, MIRRORS - 1, 4, 0));
        rd("R5 mirror page3", reg_addr(3, 7, 4, 1));
        // R7: overwrite high byte only
        wr(reg_addr(3, 1, 4, 0), 8'h5E);
        check("R7 reg4 low kept", {16'd0, regs_o[4*16 +: 16]}, 32'h00005ECD);
        check_regs("R7 others");
        // R9: every register lane
        for (int i = 0; i < NUM_REGS; i++) begin
            wr(reg_addr(i % 4, i, i, 0), 8'(8'h10 + i));
            wr(reg_addr(i % 4, i + 1, i, 1), 8'(8'hE0 - i));
        end
        check_regs("R9 lanes");

        // R10: rdata holds over idle and write cycles
        rd("R4 before hold", col_addr(0, 7));
        hold_v = rdata;
        repeat (3) begin
            @(negedge clk);
            check("R10 idle", {24'd0, rdata}, {24'd0, hold_v});
        end
        wr(col_addr(0, 7), 8'h99);
        @(negedge clk);
        check("R10 after write", {24'd0, rdata}, {24'd0, hold_v});
        rd("R4 after write", col_addr(0, 7));

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            ra = ADDR_W'($urandom);
            if ($urandom_range(1, 0) == 1) wr(ra, 8'($urandom));
            else                           rd("R4 random read", ra);
            if ((n % 16) == 0) check_regs("R9 random");
        end

        // R8: reset again clears registers, colour memory kept
        @(negedge clk);
        rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        for (int i = 0; i < NUM_REGS; i++) m_reg[i] = '0;
        @(negedge clk);
        check("R8 rdata again", {24'd0, rdata}, 32'd0);
        check_regs("R8 regs again");
        rd("R4 after reset", col_addr(1, 5));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule